// File: doc/BRIEF.md
# Level-Transparent Register Bank

A bank of `DEPTH` data registers, `DW` bits each, with one write port and one read port that work at the same time. The write port is transparent while its level input sits at the active polarity. On every clock edge during that window, the register chosen by the write address takes the data input. When the level returns to idle, the last value taken stays in that register.

The read port is combinational on the chosen register. When the read address equals an active, in-range write address, the incoming data goes straight to the output. Either address at or above `DEPTH` shuts off its own port. A write to such an address changes nothing. A read from such an address freezes the output at the value it showed at the last clock edge with a valid read address.

`ACT_HIGH` selects whether the write level is active high or active low. `INIT` gives the output's starting value.

Top module: `rset_level_bank`

## Requirements
- R1: While and after asynchronous reset, every register holds 0. Before any valid read has been clocked, the output shows `INIT` for an out-of-range read address and 0 for an in-range one.
- R2: When `wr_lvl_i` is at the active level and `wr_addr_i < DEPTH`, the addressed register takes `wr_data_i` at every clock edge. A value change in the middle of the window is followed.
- R3: After the write level returns to idle, the register keeps the last value it took.
- R4: While the write level is idle, no register changes, whatever the write address and data are.
- R5: A write with `wr_addr_i >= DEPTH` leaves every register unchanged.
- R6: With `rd_addr_i < DEPTH`, `rd_data_o` shows the addressed register combinationally.
- R7: With the write level active and `rd_addr_i == wr_addr_i < DEPTH`, `rd_data_o` equals `wr_data_i` in the same cycle.
- R8: With `rd_addr_i >= DEPTH`, `rd_data_o` holds the value it showed at the last clock edge where the read address was in range, or `INIT` if there was none.
- R9: A write to one register does not disturb a concurrent read of a different register.
- R10: With `ACT_HIGH = 0`, writes occur while `wr_lvl_i` is 0, and a level of 1 is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that samples the write window |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_lvl_i | input | 1 | Write level; active polarity set by ACT_HIGH |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | DW | Read data |

## Verification
The hardest state to reach from the ports is the frozen output. It depends on which value was on the read port at the last clock edge with a valid read address, not on the current register contents. The stimulus first clocks a read of a register with known contents. It then moves the read address out of range and rewrites that same register underneath. The output must keep the old value. The same-address bypass is checked in the cycle before the write edge, which separates it from an ordinary read after the write.

// File: rtl/rset_pkg.sv
package rset_pkg;
  localparam int unsigned WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rset_wr_dec.sv
module rset_wr_dec #(
  parameter int unsigned DEPTH    = 12,
  parameter int unsigned AW       = 4,
  parameter bit          ACT_HIGH = 1'b1
) (
  input  logic             wr_lvl_i,
  input  logic [AW-1:0]    wr_addr_i,
  output logic             wr_hit_o,
  output logic [DEPTH-1:0] we_o
);
  logic lvl_act;
  logic addr_ok;

  generate
    if (ACT_HIGH) begin : g_pos
      assign lvl_act = wr_lvl_i;
    end else begin : g_neg
      assign lvl_act = ~wr_lvl_i;
    end
  endgenerate

  assign addr_ok  = ({1'b0, wr_addr_i} < (AW+1)'(DEPTH));
  assign wr_hit_o = lvl_act & addr_ok;

  for (genvar i = 0; i < DEPTH; i++) begin : g_we
    assign we_o[i] = wr_hit_o & (wr_addr_i == AW'(i));
  end
endmodule

// File: rtl/rset_bank.sv
module rset_bank #(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned DW    = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DEPTH-1:0]        we_i,
  input  logic [DW-1:0]           wr_data_i,
  output logic [DEPTH-1:0][DW-1:0] mem_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mem_o[i] <= '0;
      else if (we_i[i]) mem_o[i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/rset_rd_port.sv
module rset_rd_port #(
  parameter int unsigned        DEPTH = 12,
  parameter int unsigned        AW    = 4,
  parameter int unsigned        DW    = 16,
  parameter logic [DW-1:0]      INIT  = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DEPTH-1:0][DW-1:0] mem_i,
  input  logic                     wr_hit_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [DW-1:0]            wr_data_i,
  input  logic [AW-1:0]            rd_addr_i,
  output logic [DW-1:0]            rd_data_o
);
  logic          rd_ok;
  logic          fwd;
  logic [DW-1:0] sel_word;
  logic [DW-1:0] hold_q;

  assign rd_ok = ({1'b0, rd_addr_i} < (AW+1)'(DEPTH));
  assign fwd   = wr_hit_i & (wr_addr_i == rd_addr_i);

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_addr_i == AW'(i)) sel_word = mem_i[i];
    end
  end

  // bypass the incoming word when both ports hit the same register
  assign rd_data_o = !rd_ok ? hold_q : (fwd ? wr_data_i : sel_word);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= INIT;
    else if (rd_ok) hold_q <= rd_data_o;
  end
endmodule

// File: rtl/rset_level_bank.sv
module rset_level_bank #(
  parameter int unsigned   DEPTH    = 12,
  parameter int unsigned   AW       = 4,
  parameter int unsigned   DW       = rset_pkg::WORD_W,
  parameter bit            ACT_HIGH = 1'b1,
  parameter logic [DW-1:0] INIT     = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lvl_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned MAX_DEPTH = 1 << AW;

  initial begin
    if (DEPTH > MAX_DEPTH || DEPTH == 0) $error("DEPTH must be in 1..2**AW");
  end

  logic [DEPTH-1:0]         we;
  logic                     wr_hit;
  logic [DEPTH-1:0][DW-1:0] mem;

  rset_wr_dec #(.DEPTH(DEPTH), .AW(AW), .ACT_HIGH(ACT_HIGH)) u_dec (
    .wr_lvl_i (wr_lvl_i),
    .wr_addr_i(wr_addr_i),
    .wr_hit_o (wr_hit),
    .we_o     (we)
  );

  rset_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .wr_data_i(wr_data_i),
    .mem_o    (mem)
  );

  rset_rd_port #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .INIT(INIT)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mem_i    (mem),
    .wr_hit_i (wr_hit),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/rset_level_bank_chk.sv
module rset_level_bank_chk #(
  parameter int unsigned   DEPTH    = 12,
  parameter int unsigned   AW       = 4,
  parameter int unsigned   DW       = 16,
  parameter bit            ACT_HIGH = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_lvl_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic [AW-1:0] rd_addr_i,
  input logic [DW-1:0] rd_data_o
);
  logic wr_on, ra_ok, same;
  assign wr_on = (wr_lvl_i == ACT_HIGH) && ({1'b0, wr_addr_i} < (AW+1)'(DEPTH));
  assign ra_ok = ({1'b0, rd_addr_i} < (AW+1)'(DEPTH));
  assign same  = wr_on && ra_ok && (wr_addr_i == rd_addr_i);

  logic          seen_q, pv_wr, pv_ra_ok;
  logic [AW-1:0] pv_waddr, pv_raddr;
  logic [DW-1:0] pv_wdata, pv_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0; pv_wr <= 1'b0; pv_ra_ok <= 1'b0;
      pv_waddr <= '0; pv_raddr <= '0; pv_wdata <= '0; pv_rd <= '0;
    end else begin
      seen_q <= 1'b1; pv_wr <= wr_on; pv_ra_ok <= ra_ok;
      pv_waddr <= wr_addr_i; pv_raddr <= rd_addr_i;
      pv_wdata <= wr_data_i; pv_rd <= rd_data_o;
    end
  end

  p_bypass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same |-> rd_data_o == wr_data_i);

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && pv_wr && ra_ok && rd_addr_i == pv_waddr && !same)
      |-> rd_data_o == pv_wdata);

  p_read_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !ra_ok) |-> rd_data_o == pv_rd);

  // also covers R5: an out-of-range write leaves pv_wr low
  p_idle_no_change_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !pv_wr && pv_ra_ok && ra_ok && rd_addr_i == pv_raddr && !same)
      |-> rd_data_o == pv_rd);
endmodule

bind rset_level_bank rset_level_bank_chk #(
  .DEPTH(DEPTH), .AW(AW), .DW(DW), .ACT_HIGH(ACT_HIGH)
) u_chk (.*);

// File: tb/sim_rset_level_bank.sv
module sim_rset_level_bank;
  localparam int unsigned   DEPTH = 12;
  localparam int unsigned   AW    = 4;
  localparam int unsigned   DW    = 16;
  localparam logic [DW-1:0] INIT  = 16'h5A3C;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          lvl, lvl_n;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rd0, rd1;

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] model [DEPTH];

  always #2.5 clk_i = ~clk_i;

  rset_level_bank #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .ACT_HIGH(1'b1), .INIT(INIT)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_lvl_i(lvl), .wr_addr_i(waddr),
    .wr_data_i(wdata), .rd_addr_i(raddr), .rd_data_o(rd0));

  rset_level_bank #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .ACT_HIGH(1'b0), .INIT(INIT)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_lvl_i(lvl_n), .wr_addr_i(waddr),
    .wr_data_i(wdata), .rd_addr_i(raddr), .rd_data_o(rd1));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    raddr = 4'd15; #1;
    check("R1 init out", rd0, INIT);
    raddr = 4'd3; #1;
    check("R1 reg zero", rd0, 16'h0000);
  endtask

  task automatic t_write_hold();
    raddr = 4'd0;
    lvl = 1'b1; waddr = 4'd3; wdata = 16'h1234; tick();
    wdata = 16'h4321; tick();
    lvl = 1'b0; model[3] = 16'h4321;
    raddr = 4'd3; #1;
    check("R2 follow", rd0, 16'h4321);
    tick();
    check("R3 hold", rd0, 16'h4321);
    waddr = 4'd3; wdata = 16'hFFFF; tick(); tick();
    check("R4 idle", rd0, 16'h4321);
  endtask

  task automatic t_oor_write();
    lvl = 1'b1; wdata = 16'hBEEF;
    for (int a = 12; a < 16; a++) begin
      waddr = AW'(a); tick();
    end
    lvl = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      raddr = AW'(a); #1;
      check("R5 oor write", rd0, model[a]);
    end
  endtask

  task automatic t_bypass();
    raddr = 4'd5; waddr = 4'd5; wdata = 16'h7777; lvl = 1'b1; #1;
    check("R7 bypass", rd0, 16'h7777);
    tick(); lvl = 1'b0; model[5] = 16'h7777; #1;
    check("R7 after", rd0, 16'h7777);
  endtask

  task automatic t_concurrent();
    raddr = 4'd3; waddr = 4'd6; wdata = 16'h1111; lvl = 1'b1; #1;
    check("R9 concurrent", rd0, model[3]);
    tick(); lvl = 1'b0; model[6] = 16'h1111;
    check("R9 after", rd0, model[3]);
    raddr = 4'd6; #1;
    check("R6 read", rd0, 16'h1111);
  endtask

  task automatic t_oor_read();
    raddr = 4'd3; tick();
    raddr = 4'd14; #1;
    check("R8 freeze", rd0, 16'h4321);
    lvl = 1'b1; waddr = 4'd3; wdata = 16'h9999; tick(); tick();
    lvl = 1'b0; model[3] = 16'h9999;
    check("R8 still", rd0, 16'h4321);
    raddr = 4'd3; #1;
    check("R8 resume", rd0, 16'h9999);
  endtask

  task automatic t_neg();
    lvl_n = 1'b0; waddr = 4'd2; wdata = 16'hABCD; tick();
    lvl_n = 1'b1; waddr = 4'd2; wdata = 16'h0F0F; tick();
    raddr = 4'd2; #1;
    check("R10 neg write", rd1, 16'hABCD);
    check("R10 pos idle", rd0, model[2]);
  endtask

  initial begin
    lvl = 1'b0; lvl_n = 1'b1; waddr = '0; raddr = '0; wdata = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_write_hold();
    t_oor_write();
    t_bypass();
    t_concurrent();
    t_oor_read();
    t_neg();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #20000;
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule